// File: doc/BRIEF.md
# Serial Receive Character Queue

This block sits behind the bit-level deserializer of an asynchronous serial receiver. Each time the deserializer finishes a character it pulses a strobe and presents up to nine data bits together with a parity-error flag and a framing-error flag. The block keeps these characters, with their flags, in an eight-entry first-in first-out queue. Software drains it through a small register port.

The block raises a level-sensitive interrupt request while the queue holds at least a chosen number of characters. In nine-bit mode it can be told to keep only address characters, which are those with bit 8 set. When a character arrives with no room in the queue, the block sets a sticky overrun flag and refuses further characters. Software clears the flag by writing 0 to it. That write also empties the queue and pulses a reset to the deserializer's shift register.

Register port: `reg_sel` = 0 selects the control/status word and `reg_sel` = 1 selects the data word. `reg_rdata` always shows the selected word combinationally. A `reg_rd` strobe with `reg_sel` = 1 pops the head character. A `reg_wr` strobe with `reg_sel` = 0 writes the control fields.

Control/status word bits:

- [1:0]: threshold select (read/write)
- [2]: address-filter enable (read/write)
- [3]: nine-bit mode (read/write)
- [4]: overrun flag (read; writing 0 clears it)
- [5]: data available (read-only)
- [6]: receiver idle (read-only)
- [7]: head parity error (read-only)
- [8]: head framing error (read-only)

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty, the status word reads 0 except idle (bit 6 = !rx_busy), and irq is 0.
- R2: Characters are read from the data word ([8:0]) in arrival order. Status bits 7 and 8 show the parity and framing flags of the head character, move to the next character on each pop, and read 0 when the queue is empty.
- R3: A character that arrives while 8 are held is dropped and sets the overrun flag (bit 4). While the flag is set, every arriving character is dropped, even after pops have freed space.
- R4: Writing the control word with bit 4 = 0 while overrun is set clears the flag, empties the queue, and drives deser_flush high during that write cycle. If a character arrives in the same cycle, it is lost. Writing bit 4 = 1, or writing 0 while the flag is clear, changes neither the flag nor the queue, and deser_flush stays 0.
- R5: irq is high exactly while the queue holds at least 1 character (threshold 00), at least 4 (threshold 01), or at least 6 (threshold 10).
- R6: Threshold code 11 makes irq behave as for code 00.
- R7: With nine-bit mode (bit 3) and address filter (bit 2) both set, a character with bit 8 = 0 is discarded without being stored, and a character with bit 8 = 1 is stored.
- R8: In eight-bit mode the address filter has no effect, and stored characters read back with bit 8 = 0.
- R9: Status bit 5 is 1 while at least one character is held, and 0 otherwise.
- R10: Status bit 6 equals the inverse of rx_busy.
- R11: Reading the data word while the queue is empty returns 0 and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | One-cycle strobe: a character has completed |
| chr_data | input | 9 | Received character bits |
| chr_perr | input | 1 | Parity error of the completed character |
| chr_ferr | input | 1 | Framing error of the completed character |
| rx_busy | input | 1 | Deserializer is receiving a character |
| reg_sel | input | 1 | 0 = control/status word, 1 = data word |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; pops the queue when reg_sel = 1 |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Selected word |
| irq | output | 1 | Level interrupt request |
| deser_flush | output | 1 | Shift-register reset to the deserializer |

## Verification
The queue is fed three kinds of character stream:

- Directed streams that fill it to exactly eight and one past. These separate a correct full boundary from an off-by-one, and show that the overrun flag blocks intake until it is cleared.
- Threshold sweeps at every fill level from 0 to 8 under all four threshold codes. These tell the 1/4/6 comparisons apart from each other and show that the reserved code falls back to the code 00 behaviour.
- Mixed address and non-address characters in both data-width modes. These separate the filter from the eight-bit masking.

A seeded random mix of arrivals, pops and control writes then checks ordering, flag pairing and the clear-with-flush rule against a reference queue kept in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int CHAR_W = 9;
    localparam int REG_W  = 9;

    localparam int B_THR_LO  = 0;
    localparam int B_ADDR_EN = 2;
    localparam int B_NINE    = 3;
    localparam int B_OVF     = 4;
    localparam int B_AVAIL   = 5;
    localparam int B_IDLE    = 6;
    localparam int B_PERR    = 7;
    localparam int B_FERR    = 8;

    typedef enum logic [1:0] {
        THR_ANY  = 2'b00,
        THR_HALF = 2'b01,
        THR_3Q   = 2'b10,
        THR_RSVD = 2'b11
    } thr_sel_e;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    typedef struct packed {
        thr_sel_e thr;
        logic     addr_en;
        logic     nine_bit;
    } rx_ctrl_t;

    // Fill level at which the interrupt asserts; reserved code acts as "any".
    function automatic int unsigned fill_level(thr_sel_e sel, int unsigned depth);
        case (sel)
            THR_HALF: fill_level = depth / 2;
            THR_3Q:   fill_level = (3 * depth) / 4;
            default:  fill_level = 1;
        endcase
    endfunction

endpackage

// File: rtl/rxq_filter.sv
module rxq_filter
    import rxq_pkg::*;
(
    input  rx_ctrl_t ctrl,
    input  rx_char_t chr_in,
    output logic     keep,
    output rx_char_t chr_out
);
    always_comb begin
        chr_out = chr_in;
        if (!ctrl.nine_bit) begin
            chr_out.data[CHAR_W-1] = 1'b0;
        end
        keep = !(ctrl.nine_bit && ctrl.addr_en && !chr_in.data[CHAR_W-1]);
    end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  rx_char_t                   wr_item,
    input  logic                       pop,
    output rx_char_t                   rd_item,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    rx_char_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    logic do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rd_item = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wr_item;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  thr_sel_e                   thr,
    output logic                       irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] level;

    always_comb begin
        level = CNT_W'(fill_level(thr, DEPTH));
        irq   = (count >= level);
    end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chr_valid,
    input  logic [8:0]       chr_data,
    input  logic             chr_perr,
    input  logic             chr_ferr,
    input  logic             rx_busy,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [8:0]       reg_wdata,
    output logic [8:0]       reg_rdata,
    output logic             irq,
    output logic             deser_flush
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_ctrl_t         ctrl;
    logic             ovf;
    rx_char_t         in_chr, kept_chr, head;
    logic             keep;
    logic             accept, push, pop, full, empty;
    logic             ctrl_wr, clear_ovf;
    logic [CNT_W-1:0] count;
    logic [REG_W-1:0] status;

    assign in_chr = '{data: chr_data, perr: chr_perr, ferr: chr_ferr};

    rxq_filter u_filt (
        .ctrl    (ctrl),
        .chr_in  (in_chr),
        .keep    (keep),
        .chr_out (kept_chr)
    );

    assign ctrl_wr     = reg_wr && (reg_sel == SEL_CTRL);
    assign clear_ovf   = ctrl_wr && !reg_wdata[B_OVF] && ovf;
    assign deser_flush = clear_ovf;
    assign accept      = chr_valid && keep;
    assign push        = accept && !ovf;
    assign pop         = reg_rd && (reg_sel == SEL_DATA);

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (clear_ovf),
        .push    (push),
        .wr_item (kept_chr),
        .pop     (pop),
        .rd_item (head),
        .count   (count),
        .full    (full),
        .empty   (empty)
    );

    rxq_irq #(.DEPTH(DEPTH)) u_irq (
        .count (count),
        .thr   (ctrl.thr),
        .irq   (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{thr: THR_ANY, addr_en: 1'b0, nine_bit: 1'b0};
            ovf  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl.thr      <= thr_sel_e'(reg_wdata[B_THR_LO +: 2]);
                ctrl.addr_en  <= reg_wdata[B_ADDR_EN];
                ctrl.nine_bit <= reg_wdata[B_NINE];
            end
            if (clear_ovf) begin
                ovf <= 1'b0;
            end else if (accept && full) begin
                ovf <= 1'b1;
            end
        end
    end

    always_comb begin
        status               = '0;
        status[B_THR_LO +: 2] = ctrl.thr;
        status[B_ADDR_EN]    = ctrl.addr_en;
        status[B_NINE]       = ctrl.nine_bit;
        status[B_OVF]        = ovf;
        status[B_AVAIL]      = !empty;
        status[B_IDLE]       = !rx_busy;
        status[B_PERR]       = !empty && head.perr;
        status[B_FERR]       = !empty && head.ferr;
        if (reg_sel == SEL_DATA) begin
            reg_rdata = empty ? '0 : head.data;
        end else begin
            reg_rdata = status;
        end
    end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       chr_valid,
    input logic [8:0]                 chr_data,
    input logic                       reg_sel,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [8:0]                 reg_wdata,
    input logic                       irq,
    input logic                       deser_flush,
    input logic                       ovf,
    input logic                       nine_bit,
    input logic                       addr_en,
    input logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clr_req;
    assign clr_req = reg_wr && !reg_sel && !reg_wdata[4];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R3

    AST_FULL_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) && chr_valid && (!nine_bit || !addr_en || chr_data[8]) && !clr_req
        |=> ovf); // R3

    AST_OVF_BLOCKS_INTAKE: assert property (@(posedge clk) disable iff (rst)
        ovf && !deser_flush |=> count <= $past(count)); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf && !clr_req |=> ovf); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        deser_flush |=> (count == '0) && !ovf); // R4

    AST_ADDR_DROP: assert property (@(posedge clk) disable iff (rst)
        nine_bit && addr_en && chr_valid && !chr_data[8] && !reg_rd && !deser_flush
        |=> count == $past(count)); // R7

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        irq |-> count != '0); // R5
endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .chr_valid   (chr_valid),
    .chr_data    (chr_data),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .irq         (irq),
    .deser_flush (deser_flush),
    .ovf         (ovf),
    .nine_bit    (ctrl.nine_bit),
    .addr_en     (ctrl.addr_en),
    .count       (count)
);

// File: tb/sim_rxq_top.sv
`timescale 1ns/1ps
module sim_rxq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chr_valid = 1'b0;
    logic [8:0] chr_data = '0;
    logic       chr_perr = 1'b0;
    logic       chr_ferr = 1'b0;
    logic       rx_busy = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [8:0] reg_wdata = '0;
    logic [8:0] reg_rdata;
    logic       irq;
    logic       deser_flush;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    logic [10:0] mq[$];
    logic        m_ovf = 0;
    logic [1:0]  m_thr = 0;
    logic        m_aen = 0;
    logic        m_nine = 0;

    always #10 clk = ~clk;

    rxq_top u0 (
        .clk(clk), .rst(rst), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_perr(chr_perr), .chr_ferr(chr_ferr), .rx_busy(rx_busy),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .deser_flush(deser_flush)
    );

    function automatic logic [8:0] exp_status();
        logic [8:0] s;
        s = '0;
        s[1:0] = m_thr;
        s[2] = m_aen;
        s[3] = m_nine;
        s[4] = m_ovf;
        s[5] = (mq.size() != 0);
        s[6] = !rx_busy;
        if (mq.size() != 0) begin
            s[7] = mq[0][1];
            s[8] = mq[0][0];
        end
        return s;
    endfunction

    function automatic logic exp_irq();
        int lvl;
        lvl = (m_thr == 2'b01) ? 4 : (m_thr == 2'b10) ? 6 : 1;
        return mq.size() >= lvl;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_st(string req);
        reg_sel = 1'b0;
        #1;
        check(req, 32'(reg_rdata), 32'(exp_status()));
        check(req, 32'(irq), 32'(exp_irq()));
    endtask

    task automatic send(logic [8:0] d, logic pe, logic fe);
        logic [8:0] dd;
        @(negedge clk);
        chr_valid = 1'b1; chr_data = d; chr_perr = pe; chr_ferr = fe;
        @(posedge clk);
        dd = m_nine ? d : {1'b0, d[7:0]};
        if (!(m_nine && m_aen && !d[8])) begin
            if (m_ovf) begin
            end else if (mq.size() == 8) begin
                m_ovf = 1'b1;
            end else begin
                mq.push_back({dd, pe, fe});
            end
        end
        #1 chr_valid = 1'b0;
    endtask

    task automatic rd_data(string req);
        logic [8:0] e;
        @(negedge clk);
        reg_sel = 1'b1; reg_rd = 1'b1;
        #1;
        e = (mq.size() != 0) ? mq[0][10:2] : 9'h0;
        check(req, 32'(reg_rdata), 32'(e));
        @(posedge clk);
        if (mq.size() != 0) void'(mq.pop_front());
        #1 reg_rd = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic wr_ctrl(logic [1:0] thr, logic aen, logic nine, logic ovb);
        logic clr;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b1;
        reg_wdata = {5'b0, ovb, nine, aen, thr};
        clr = m_ovf && !ovb;
        #1 check("R4", 32'(deser_flush), 32'(clr));
        @(posedge clk);
        if (clr) begin
            mq.delete();
            m_ovf = 1'b0;
        end
        m_thr = thr; m_aen = aen; m_nine = nine;
        #1 reg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        chk_st("R1");

        // R2, R9: ordering and flag pairing
        send(9'h041, 1'b1, 1'b0);
        chk_st("R9");
        send(9'h082, 1'b0, 1'b1);
        send(9'h0C3, 1'b1, 1'b1);
        chk_st("R2");
        rd_data("R2"); chk_st("R2");
        rd_data("R2"); chk_st("R2");
        rd_data("R2"); chk_st("R9");

        // R11: empty read
        rd_data("R11"); chk_st("R11");

        // R5, R6: threshold sweep, every fill level and code
        for (int n = 0; n <= 8; n++) begin
            for (int t = 0; t < 4; t++) begin
                wr_ctrl(2'(t), 1'b0, 1'b0, 1'b1);
                chk_st(t == 3 ? "R6" : "R5");
            end
            if (n < 8) send(9'(n + 16), 1'b0, 1'b0);
        end

        // R3: overrun at full
        send(9'h0AA, 1'b0, 1'b0);
        chk_st("R3");
        send(9'h0AB, 1'b0, 1'b0);
        chk_st("R3");
        rd_data("R3");
        send(9'h0AC, 1'b0, 1'b0);
        chk_st("R3");

        // R4: write 1 keeps flag, write 0 clears and flushes
        wr_ctrl(2'b00, 1'b0, 1'b0, 1'b1);
        chk_st("R4");
        wr_ctrl(2'b00, 1'b0, 1'b0, 1'b0);
        chk_st("R4");
        wr_ctrl(2'b00, 1'b0, 1'b0, 1'b0);
        chk_st("R4");

        // R7: address filter in nine-bit mode
        wr_ctrl(2'b00, 1'b1, 1'b1, 1'b1);
        send(9'h0AA, 1'b0, 1'b0);
        chk_st("R7");
        send(9'h155, 1'b1, 1'b0);
        chk_st("R7");
        rd_data("R7");

        // R8: filter ignored in eight-bit mode, bit 8 masked
        wr_ctrl(2'b00, 1'b1, 1'b0, 1'b1);
        send(9'h0AA, 1'b0, 1'b0);
        send(9'h1BB, 1'b0, 1'b1);
        chk_st("R8");
        rd_data("R8");
        rd_data("R8");

        // R10: idle follows rx_busy
        @(negedge clk) rx_busy = 1'b1;
        chk_st("R10");
        @(negedge clk) rx_busy = 1'b0;
        chk_st("R10");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom % 10;
            if (r < 5) begin
                @(negedge clk) rx_busy = 1'($urandom);
                send(9'($urandom), 1'($urandom), 1'($urandom));
                chk_st("R3");
            end else if (r < 8) begin
                rd_data("R2");
                chk_st("R2");
            end else begin
                wr_ctrl(2'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) != 0);
                chk_st("R4");
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule